// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Controller

This block sits between the digital data path and the current cells of a segmented current-steering converter. Each accepted input word is split into two fields. The upper field is expanded into a cumulative one-hot-run code, and that code is spread over equal-weight unit cells. The lower field directly drives binary-weighted cells. Unit cells switch on in order from the centre of the row outward, alternating left and right. A linear gradient across the row then cancels in pairs instead of building up.

Both fields travel through the same number of register stages, so they reach the final bank at the same time. The final bank holds one flop per cell control, and all of them update on a single clock edge. A pulse on the input qualifier loads a new word. Between words the cell controls keep their last value, so the analog output stays steady.

Top module: `segdac_ctrl`

## Requirements
- R1: The input word is `MSB_W + LSB_W` bits wide. Bits `[MSB_W+LSB_W-1:LSB_W]` form the unit field and bits `[LSB_W-1:0]` form the binary field. The block drives `2^MSB_W - 1` unit-cell enables and `LSB_W` binary-cell enables.
- R2: After a word is accepted, the number of asserted unit-cell enables equals the value of its unit field.
- R3: Unit-cell enables are cumulative. For two accepted words whose unit fields satisfy a <= b, every cell enabled for a is also enabled for b.
- R4: With N unit cells and c = floor(N/2), the k-th enabled cell (k = 0, 1, 2, ...) has physical index c when k = 0. For odd k its index is c-(k+1)/2, and for even k > 0 its index is c+k/2. With the defaults, unit field 1 gives `unit_en = 15'h0080`, 2 gives `15'h00C0` and 3 gives `15'h01C0`.
- R5: `bin_en[i]` equals bit i of the binary field of the same accepted word.
- R6: A word presented with `code_vld` high at clock edge t appears on `unit_en` and `bin_en` after edge t+1. At that edge `out_vld` is high for exactly one cycle.
- R7: When no word was accepted at edge t, `unit_en` and `bin_en` keep their values across edge t+1, and `out_vld` is low.
- R8: While the synchronous active-high `rst` is asserted at a clock edge, all enables and `out_vld` are zero after that edge.
- R9: Each unit cell is weighted 2^LSB_W and binary cell i is weighted 2^i. The weighted sum of the asserted enables equals the last accepted word exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| code_vld | input | 1 | Qualifies `code` for loading |
| code | input | MSB_W+LSB_W | Binary input word |
| unit_en | output | 2^MSB_W-1 | Unit-cell switch controls, physical order |
| bin_en | output | LSB_W | Binary-weighted cell switch controls |
| out_vld | output | 1 | One-cycle pulse when new controls are applied |

## Verification
The hardest situation to reach from the ports is the interaction between a gap in `code_vld` and the two-stage pipeline. A word accepted just before an idle cycle must still appear one edge later. The idle cycle must then leave the controls untouched. Random stimulus leaves the qualifier low about a quarter of the time, so isolated and back-to-back gaps both occur many times. A bench model tracks the outputs every cycle through those gaps. Directed words cover the first three centre-out cells, full scale and zero. A reset arrives in the middle of traffic.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

   // Physical cell index for the rank-th enabled unit cell out of n cells:
   // centre first, then alternately one step left and one step right.
   function automatic int sym_pos(input int rank, input int n);
      int ctr;
      ctr = n / 2;
      if (rank == 0)
         return ctr;
      else if ((rank % 2) == 1)
         return ctr - (rank + 1) / 2;
      else
         return ctr + rank / 2;
   endfunction

endpackage

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
   parameter int IN_W  = 4,
   parameter int OUT_W = (1 << IN_W) - 1
) (
   input  logic [IN_W-1:0]  bin_val,
   output logic [OUT_W-1:0] run_code
);

   if (OUT_W != (1 << IN_W) - 1) begin : g_bad_width
      $error("segdac_therm_dec: OUT_W must equal 2**IN_W-1");
   end

   for (genvar i = 0; i < OUT_W; i++) begin : g_bit
      assign run_code[i] = (bin_val > IN_W'(i));
   end

endmodule

// File: rtl/segdac_sym_map.sv
module segdac_sym_map #(
   parameter int N = 15
) (
   input  logic [N-1:0] rank_en,
   output logic [N-1:0] cell_en
);

   for (genvar g = 0; g < N; g++) begin : g_route
      localparam int P = segdac_pkg::sym_pos(g, N);
      if (P < 0 || P >= N) begin : g_bad_pos
         $error("segdac_sym_map: position out of range");
      end
      assign cell_en[P] = rank_en[g];
   end

   // R4
   always_comb begin
      perm_count_chk : assert ($countones(cell_en) == $countones(rank_en))
         else $error("segdac_sym_map: mapping lost or duplicated a cell");
   end

endmodule

// File: rtl/segdac_delay.sv
module segdac_delay #(
   parameter int W     = 4,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("segdac_delay: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)     q <= '0;
         else if (en) q <= din;
      end
      assign dout = q;
   end else begin : g_chain
      logic [W-1:0] q [DEPTH];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int s = 0; s < DEPTH; s++) q[s] <= '0;
         end else if (en) begin
            q[0] <= din;
            for (int s = 1; s < DEPTH; s++) q[s] <= q[s-1];
         end
      end
      assign dout = q[DEPTH-1];
   end

endmodule

// File: rtl/segdac_ctrl.sv
module segdac_ctrl #(
   parameter int MSB_W = 4,
   parameter int LSB_W = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         code_vld,
   input  logic [MSB_W+LSB_W-1:0]       code,
   output logic [(1 << MSB_W)-2:0]      unit_en,
   output logic [LSB_W-1:0]             bin_en,
   output logic                         out_vld
);

   localparam int CODE_W  = MSB_W + LSB_W;
   localparam int N_UNIT  = (1 << MSB_W) - 1;
   localparam int DEC_LAT = 1;

   if (MSB_W < 1 || MSB_W > 10) begin : g_bad_msb
      $error("segdac_ctrl: MSB_W out of range 1..10");
   end
   if (LSB_W < 1 || LSB_W > 16) begin : g_bad_lsb
      $error("segdac_ctrl: LSB_W out of range 1..16");
   end

   logic [MSB_W-1:0]  msb_f;
   logic [LSB_W-1:0]  lsb_f;
   logic [N_UNIT-1:0] run_d;
   logic [N_UNIT-1:0] run_q;
   logic [N_UNIT-1:0] cell_map;
   logic [LSB_W-1:0]  lsb_q;
   logic              vld_q;

   assign msb_f = code[CODE_W-1:LSB_W];
   assign lsb_f = code[LSB_W-1:0];

   // Stage 1: unit field decoded and registered
   segdac_therm_dec #(.IN_W(MSB_W), .OUT_W(N_UNIT)) u_dec (
      .bin_val (msb_f),
      .run_code(run_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
         vld_q <= 1'b0;
      end else begin
         if (code_vld) run_q <= run_d;
         vld_q <= code_vld;
      end
   end

   // Stage 1: binary field through a matched dummy delay
   segdac_delay #(.W(LSB_W), .DEPTH(DEC_LAT)) u_lsb_dly (
      .clk (clk),
      .rst (rst),
      .en  (code_vld),
      .din (lsb_f),
      .dout(lsb_q)
   );

   segdac_sym_map #(.N(N_UNIT)) u_map (
      .rank_en(run_q),
      .cell_en(cell_map)
   );

   // Stage 2: one retiming flop per cell control
   always_ff @(posedge clk) begin
      if (rst) begin
         unit_en <= '0;
         bin_en  <= '0;
         out_vld <= 1'b0;
      end else begin
         if (vld_q) begin
            unit_en <= cell_map;
            bin_en  <= lsb_q;
         end
         out_vld <= vld_q;
      end
   end

   // R8
   rst_clear_chk : assert property (@(posedge clk)
      $past(rst) |-> (unit_en == '0 && bin_en == '0 && !out_vld));

   // R2
   unit_count_chk : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst, 1) && !$past(rst, 2) && $past(code_vld, 2))
      |-> ($countones(unit_en) == int'($past(msb_f, 2))));

   // R5
   bin_match_chk : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst, 1) && !$past(rst, 2) && $past(code_vld, 2))
      |-> (bin_en == $past(lsb_f, 2)));

   // R6
   vld_lat_chk : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst, 1) && !$past(rst, 2)) |-> (out_vld == $past(code_vld, 2)));

   // R7
   idle_hold_chk : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !out_vld) |-> ($stable(unit_en) && $stable(bin_en)));

endmodule

// File: tb/tb_segdac_ctrl.sv
`timescale 1ns/1ps
module tb_segdac_ctrl;

   localparam int MW = 4;
   localparam int LW = 4;
   localparam int CW = MW + LW;
   localparam int NU = (1 << MW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          code_vld = 1'b0;
   logic [CW-1:0] code = '0;
   logic [NU-1:0] unit_en;
   logic [LW-1:0] bin_en;
   logic          out_vld;

   int n_tests = 0;
   int n_fail  = 0;

   // model state
   logic [CW-1:0] m_s1code = '0;
   logic          m_s1vld  = 1'b0;
   logic [CW-1:0] m_outcode = '0;
   logic          m_vld = 1'b0;

   always #2 clk = ~clk;

   segdac_ctrl #(.MSB_W(MW), .LSB_W(LW)) dut (
      .clk     (clk),
      .rst     (rst),
      .code_vld(code_vld),
      .code    (code),
      .unit_en (unit_en),
      .bin_en  (bin_en),
      .out_vld (out_vld)
   );

   function automatic int cell_of(input int k);
      int c;
      c = NU / 2;
      if (k == 0) return c;
      if ((k % 2) == 1) return c - (k + 1) / 2;
      return c + k / 2;
   endfunction

   function automatic logic [NU-1:0] exp_unit(input int m);
      logic [NU-1:0] v;
      v = '0;
      for (int k = 0; k < m; k++) v[cell_of(k)] = 1'b1;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, compare after it
   task automatic step(input logic [CW-1:0] c, input logic v, input logic r);
      logic [NU-1:0] eu;
      @(negedge clk);
      code = c; code_vld = v; rst = r;
      @(posedge clk);
      if (r) begin
         m_s1code = '0; m_s1vld = 1'b0; m_outcode = '0; m_vld = 1'b0;
      end else begin
         if (m_s1vld) m_outcode = m_s1code;
         m_vld = m_s1vld;
         if (v) m_s1code = c;
         m_s1vld = v;
      end
      #1;
      eu = exp_unit(int'(m_outcode[CW-1:LW]));
      check(unit_en == eu, "R2", "unit_en", longint'(unit_en), longint'(eu));
      check(bin_en == m_outcode[LW-1:0], "R5", "bin_en",
            longint'(bin_en), longint'(m_outcode[LW-1:0]));
      check(out_vld == m_vld, "R6", "out_vld", longint'(out_vld), longint'(m_vld));
      if (out_vld) begin
         int s;
         s = $countones(unit_en) * (1 << LW);
         for (int i = 0; i < LW; i++) if (bin_en[i]) s += (1 << i);
         check(s == int'(m_outcode), "R9", "weighted sum", s, m_outcode);
      end
   endtask

   initial begin
      #(60000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [NU-1:0] prev;
      void'($urandom(32'd4711));

      // R8 reset state
      step('0, 1'b0, 1'b1);
      step(8'hA5, 1'b1, 1'b1);
      check(unit_en == '0 && bin_en == '0 && !out_vld, "R8", "reset outputs",
            longint'(unit_en), 0);

      // R4 directed centre-out positions
      step(8'h10, 1'b1, 1'b0); step('0, 1'b0, 1'b0);
      check(unit_en == 15'h0080, "R4", "code 1x", longint'(unit_en), 64'h0080);
      step(8'h20, 1'b1, 1'b0); step('0, 1'b0, 1'b0);
      check(unit_en == 15'h00C0, "R4", "code 2x", longint'(unit_en), 64'h00C0);
      step(8'h30, 1'b1, 1'b0); step('0, 1'b0, 1'b0);
      check(unit_en == 15'h01C0, "R4", "code 3x", longint'(unit_en), 64'h01C0);

      // R1 full scale: all 15 unit cells and 4 binary cells
      step(8'hFF, 1'b1, 1'b0); step('0, 1'b0, 1'b0);
      check(unit_en == 15'h7FFF && bin_en == 4'hF, "R1", "full scale",
            longint'({unit_en, bin_en}), 64'h7FFFF);

      // R7 idle cycles keep the controls
      step(8'h00, 1'b0, 1'b0); step(8'h00, 1'b0, 1'b0);
      check(unit_en == 15'h7FFF && !out_vld, "R7", "hold on idle",
            longint'(unit_en), 64'h7FFF);

      // R3 ascending sweep of every code, cumulative enables
      step(8'h00, 1'b1, 1'b0); step(8'h00, 1'b0, 1'b0);
      prev = unit_en;
      for (int c = 0; c < (1 << CW); c++) begin
         step(CW'(c), 1'b1, 1'b0);
         if (out_vld) begin
            check((prev & ~unit_en) == '0, "R3", "cumulative",
                  longint'(unit_en), longint'(prev | unit_en));
            prev = unit_en;
         end
      end

      // random traffic with gaps (R6, R7, R9)
      for (int n = 0; n < 1500; n++) begin
         step(CW'($urandom), ($urandom % 4) != 0, 1'b0);
      end

      // reset in mid-traffic (R8)
      step(8'h77, 1'b1, 1'b0);
      step(8'h88, 1'b1, 1'b1);
      check(unit_en == '0 && !out_vld, "R8", "mid reset", longint'(unit_en), 0);
      for (int n = 0; n < 200; n++) begin
         step(CW'($urandom), ($urandom % 2) != 0, 1'b0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule